// File: doc/BRIEF.md
# Time-Shared Multi-Mode FIR Filter

This block is a programmable finite impulse response filter built around a fixed bank of sixteen multiply-accumulate units. Each unit can be reused over one, two, four or eight system clocks for every output. The filter therefore offers 16, 32, 64 or 128 taps, and the input sample period stretches in the same ratio. Samples are 16-bit two's complement. Coefficients are written as 16-bit two's complement words and stored as 12-bit values. Products are summed at 32 bits and wrap on overflow.

The bank can work as one filter or as two independent filters of half the length, each with its own data input and result. A decimate-by-two mode computes one result for every two input samples, which doubles the tap count available at a given input rate. A 32-bit cascade input is added without scaling into the first filter's result. That result also serves as the cascade output, so instances can be chained into longer filters.

Mode inputs are taken only while `hold` is high. Holding also clears the delay lines, the accumulators and the outputs. Once `hold` drops, a phase counter starts from zero. The filter captures input samples and produces results at fixed clock positions counted from that point.

Top module: `tmf_filter`

## Requirements
- R1: A coefficient written through the store port is kept as its 12 most significant bits (the written value divided by 16, rounded toward negative infinity). The stored value is used from the clock after the write.
- R2: With `tap_sel`=0 (16 taps, P=1), edges are counted from the first clock edge with `hold` low as k=0,1,2… The input sample is captured at every edge. After edge e+1, `res_a` equals the sum over k<16 of coef[k]·x[n−k] plus the cascade term, where n is the sample captured at edge e and samples before the hold are zero.
- R3: With `tap_sel`=s (P=2^s), samples are captured at edges k where k mod P = 0. Each result covers 16·P taps and appears after edge e+P for the sample captured at edge e.
- R4: With `dec_en`=1 and `tap_sel`≥1, the capture period is P/2 while each result still covers 16·P taps. A result is produced only for samples captured at edges that are multiples of P, so one result comes for every two samples. With `tap_sel`=0, `dec_en` has no effect.
- R5: With `split_en`=1, the bank forms two filters of 8·P taps. Filter A takes `din_a` and coefficient entries 0…8P−1 and drives `res_a`. Filter B takes `din_b` and entries 8P…16P−1 and drives `res_b`. When `split_en`=0, `res_b` stays zero.
- R6: `casc_in`, as sampled at the edge that completes a result, is added without scaling to `res_a`.
- R7: All sums wrap modulo 2^32 and never saturate.
- R8: `tap_sel`, `split_en` and `dec_en` take effect only while `hold` is high; changes while `hold` is low have no effect. Holding clears the sample history, the accumulators, `res_a`, `res_b` and `res_vld`.
- R9: `res_vld` is high for exactly the one cycle that follows each result update. In every mode with P>1 it is therefore a single-cycle pulse.
- R10: After reset, `res_a`, `res_b` and `res_vld` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Clear and mode-load request |
| tap_sel | input | 2 | Tap count select: 16<<tap_sel taps |
| split_en | input | 1 | Two half-length filters when 1 |
| dec_en | input | 1 | Decimate-by-two when 1 |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 7 | Coefficient entry (tap index) |
| coef_wdata | input | 16 | Coefficient value, two's complement |
| din_a | input | 16 | Sample input of filter A (whole filter when not split) |
| din_b | input | 16 | Sample input of filter B |
| casc_in | input | 32 | Partial result from an upstream instance |
| res_a | output | 32 | Result of filter A, also the cascade output |
| res_b | output | 32 | Result of filter B |
| res_vld | output | 1 | One-cycle strobe marking a new result |

## Verification
Every result is due a fixed number of edges after its newest sample is captured: P edges, counted from the first edge with `hold` low. The cascade term is the value present at the completing edge, one edge before the result becomes visible. The bench model advances once per clock edge with exactly the inputs the design samples at that edge. It predicts `res_a`, `res_b` and `res_vld` for the following cycle and compares all three at the falling edge after that. A result that arrives one edge early or late, or a strobe that lasts longer than one cycle, therefore shows up as a mismatch at that comparison.

// File: rtl/tmf_pkg.sv
package tmf_pkg;
  localparam int DATA_W  = 16;
  localparam int COEF_W  = 16;
  localparam int CQ_W    = 12;
  localparam int ACC_W   = 32;
  localparam int N_MAC   = 16;
  localparam int MAX_REP = 8;
endpackage

// File: rtl/tmf_coef_store.sv
module tmf_coef_store #(
  parameter int NC   = 128,
  parameter int CW   = 16,
  parameter int CQW  = 12,
  parameter int NRD  = 16,
  localparam int ABW = $clog2(NC)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [ABW-1:0]       waddr,
  input  logic [CW-1:0]        wdata,
  input  logic [NRD*ABW-1:0]   raddr,
  output logic [NRD*CQW-1:0]   rdata
);
  logic [CQW-1:0] mem [NC];

  // keep upper bits only: arithmetic floor of wdata / 2^(CW-CQW)
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata[CW-1 -: CQW];
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g*CQW +: CQW] = mem[raddr[g*ABW +: ABW]];
  end
endmodule

// File: rtl/tmf_delay_line.sv
module tmf_delay_line #(
  parameter int LEN = 129,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] taps [LEN]
);
  logic [DW-1:0] q     [LEN];
  logic [DW-1:0] q_nxt [LEN];

  always_comb begin
    for (int i = 0; i < LEN; i++) begin
      if (clr)        q_nxt[i] = '0;
      else if (shift) q_nxt[i] = (i == 0) ? din : q[i-1];
      else            q_nxt[i] = q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LEN; i++) q[i] <= '0;
    end else begin
      for (int i = 0; i < LEN; i++) q[i] <= q_nxt[i];
    end
  end

  assign taps = q;

  // R2: a captured sample becomes the newest history entry
  a_r2_newest_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clr) |=> taps[0] == $past(din));
  // R8: hold wipes the history
  a_r8_history_wiped: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (taps[0] == '0 && taps[LEN-1] == '0));
endmodule

// File: rtl/tmf_mac.sv
module tmf_mac #(
  parameter int DW  = 16,
  parameter int CQW = 12,
  parameter int AW  = 32,
  localparam int PW = DW + CQW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 first,
  input  logic signed [DW-1:0] x,
  input  logic signed [CQW-1:0] c,
  output logic [AW-1:0]        acc_nxt
);
  logic signed [PW-1:0] prod;
  logic [AW-1:0]        prod_ext;
  logic [AW-1:0]        acc_q;

  assign prod     = x * c;
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
  assign acc_nxt  = first ? prod_ext : acc_q + prod_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else          acc_q <= acc_nxt;
  end
endmodule

// File: rtl/tmf_filter.sv
module tmf_filter
  import tmf_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int CW    = COEF_W,
  parameter int CQW   = CQ_W,
  parameter int AW    = ACC_W,
  parameter int NMAC  = N_MAC,
  parameter int MAXP  = MAX_REP,
  localparam int H    = NMAC / 2,
  localparam int NC   = NMAC * MAXP,
  localparam int ABW  = $clog2(NC),
  localparam int LENA = NC + 1,
  localparam int LENB = NC / 2 + 1,
  localparam int IW   = $clog2(LENA),
  localparam int IWB  = $clog2(LENB),
  localparam int PW   = $clog2(MAXP),
  localparam int TSW  = $clog2(PW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic [TSW-1:0] tap_sel,
  input  logic           split_en,
  input  logic           dec_en,
  input  logic           coef_we,
  input  logic [ABW-1:0] coef_addr,
  input  logic [CW-1:0]  coef_wdata,
  input  logic [DW-1:0]  din_a,
  input  logic [DW-1:0]  din_b,
  input  logic [AW-1:0]  casc_in,
  output logic [AW-1:0]  res_a,
  output logic [AW-1:0]  res_b,
  output logic           res_vld
);
  // latched mode and sequencing state
  logic [TSW-1:0] tsel_q, tsel_n;
  logic           split_q, split_n, dec_q, dec_n;
  logic [PW-1:0]  ph_q, ph_n;
  logic           run_q, run_n;
  logic [AW-1:0]  ra_q, ra_n, rb_q, rb_n;
  logic           vld_q, vld_n;

  logic [PW:0]    p_len, m_len;
  logic           edec, ofs, capture, complete;
  logic [PW-1:0]  jstep;

  assign p_len    = (PW+1)'(1) << tsel_q;
  assign edec     = dec_q && (tsel_q != '0);
  assign m_len    = edec ? (p_len >> 1) : p_len;
  assign jstep    = (ph_q == '0) ? PW'(p_len - 1'b1) : ph_q - PW'(1);
  assign ofs      = edec && ({1'b0, jstep} >= m_len);
  assign capture  = !hold && ((ph_q == '0) || (edec && ({1'b0, ph_q} == m_len)));
  assign complete = run_q && (ph_q == '0);

  // sample histories
  logic [DW-1:0] tap_a [LENA];
  logic [DW-1:0] tap_b [LENB];

  tmf_delay_line #(.LEN(LENA), .DW(DW)) u_dl_a (
    .clk(clk), .rst_n(rst_n), .clr(hold), .shift(capture), .din(din_a), .taps(tap_a));
  tmf_delay_line #(.LEN(LENB), .DW(DW)) u_dl_b (
    .clk(clk), .rst_n(rst_n), .clr(hold), .shift(capture), .din(din_b), .taps(tap_b));

  // coefficient store with one read port per MAC
  logic [NMAC*ABW-1:0] c_raddr;
  logic [NMAC*CQW-1:0] c_rdata;

  tmf_coef_store #(.NC(NC), .CW(CW), .CQW(CQW), .NRD(NMAC)) u_coef (
    .clk(clk), .we(coef_we), .waddr(coef_addr), .wdata(coef_wdata),
    .raddr(c_raddr), .rdata(c_rdata));

  // MAC bank: unit g handles taps g*P .. g*P+P-1 of its filter
  logic [AW-1:0] acc_nxt [NMAC];

  for (genvar g = 0; g < NMAC; g++) begin : g_mac
    localparam int GB = (g >= H) ? g - H : g;
    logic          use_b;
    logic [IW-1:0] idx;
    logic [DW-1:0] xs;

    assign use_b = split_q && (g >= H);
    assign idx   = (IW'(use_b ? GB : g) << tsel_q) + IW'(jstep) + IW'(ofs);
    assign xs    = use_b ? tap_b[idx[IWB-1:0]] : tap_a[idx];
    assign c_raddr[g*ABW +: ABW] = (ABW'(g) << tsel_q) + ABW'(jstep);

    tmf_mac #(.DW(DW), .CQW(CQW), .AW(AW)) u_mac (
      .clk(clk), .rst_n(rst_n), .clr(hold), .first(jstep == '0),
      .x(xs), .c(c_rdata[g*CQW +: CQW]), .acc_nxt(acc_nxt[g]));
  end

  // result summation across the bank
  logic [AW-1:0] sum_a, sum_b;
  always_comb begin
    sum_a = casc_in;
    sum_b = '0;
    for (int g = 0; g < NMAC; g++) begin
      if (split_q && (g >= H)) sum_b = sum_b + acc_nxt[g];
      else                     sum_a = sum_a + acc_nxt[g];
    end
  end

  // next-state logic
  always_comb begin
    tsel_n  = tsel_q;
    split_n = split_q;
    dec_n   = dec_q;
    ph_n    = ph_q;
    run_n   = run_q;
    ra_n    = ra_q;
    rb_n    = rb_q;
    vld_n   = 1'b0;
    if (hold) begin
      tsel_n  = tap_sel;
      split_n = split_en;
      dec_n   = dec_en;
      ph_n    = '0;
      run_n   = 1'b0;
      ra_n    = '0;
      rb_n    = '0;
    end else begin
      run_n = 1'b1;
      ph_n  = ({1'b0, ph_q} == p_len - 1'b1) ? '0 : ph_q + PW'(1);
      if (complete) begin
        ra_n  = sum_a;
        rb_n  = split_q ? sum_b : '0;
        vld_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsel_q  <= '0;
      split_q <= 1'b0;
      dec_q   <= 1'b0;
      ph_q    <= '0;
      run_q   <= 1'b0;
      ra_q    <= '0;
      rb_q    <= '0;
      vld_q   <= 1'b0;
    end else begin
      tsel_q  <= tsel_n;
      split_q <= split_n;
      dec_q   <= dec_n;
      ph_q    <= ph_n;
      run_q   <= run_n;
      ra_q    <= ra_n;
      rb_q    <= rb_n;
      vld_q   <= vld_n;
    end
  end

  assign res_a   = ra_q;
  assign res_b   = rb_q;
  assign res_vld = vld_q;

  // R8: latched mode frozen while running
  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> ($stable(tsel_q) && $stable(split_q) && $stable(dec_q)));
  // R8 / R10: hold clears the outputs
  a_r10_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (res_a == '0 && res_b == '0 && !res_vld));
  // R9: strobe lasts one cycle when a result takes more than one clock
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && p_len != (PW+1)'(1)) |=> !res_vld);
  // R5: second output idle unless split
  a_r5_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !split_q |-> res_b == '0);
endmodule

// File: tb/sim_tmf_filter.sv
module sim_tmf_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hold;
  logic [1:0]  tap_sel;
  logic        split_en, dec_en;
  logic        coef_we;
  logic [6:0]  coef_addr;
  logic [15:0] coef_wdata;
  logic [15:0] din_a, din_b;
  logic [31:0] casc_in;
  logic [31:0] res_a, res_b;
  logic        res_vld;

  always #2 clk = ~clk;  // 250 MHz

  tmf_filter u0 (
    .clk(clk), .rst_n(rst_n), .hold(hold), .tap_sel(tap_sel),
    .split_en(split_en), .dec_en(dec_en), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_wdata(coef_wdata), .din_a(din_a),
    .din_b(din_b), .casc_in(casc_in), .res_a(res_a), .res_b(res_b),
    .res_vld(res_vld));

  int checks = 0;
  int errors = 0;
  string cur = "R10";

  // behavioural reference state
  int cq [128];
  int ha [160];
  int hb [160];
  int m_ts, m_sp, m_dc, e_cnt;
  int exp_a, exp_b, exp_v;
  int seed = 12345;

  function automatic int nxt_rand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'hFFFF;
  endfunction

  task automatic chk(string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", cur, what, act, expv);
    end
  endtask

  // one clock edge of the reference, using the inputs about to be sampled
  task automatic model_edge();
    int p, m, ph, s, taps, acc, accb;
    bit edec;
    if (hold) begin
      m_ts = int'(tap_sel); m_sp = int'(split_en); m_dc = int'(dec_en);
      e_cnt = 0; exp_a = 0; exp_b = 0; exp_v = 0;
      for (int i = 0; i < 160; i++) begin ha[i] = 0; hb[i] = 0; end
    end else begin
      p = 1 << m_ts;
      edec = (m_dc != 0) && (m_ts != 0);
      m = edec ? p / 2 : p;
      ph = e_cnt % p;
      exp_v = 0;
      if (ph == 0 && e_cnt > 0) begin
        s = edec ? 1 : 0;
        taps = (m_sp != 0) ? 8 * p : 16 * p;
        acc = int'(casc_in);
        for (int k = 0; k < taps; k++) acc += cq[k] * ha[k + s];
        exp_a = acc;
        accb = 0;
        if (m_sp != 0)
          for (int k = 0; k < taps; k++) accb += cq[8 * p + k] * hb[k + s];
        exp_b = accb;
        exp_v = 1;
      end
      if (ph % m == 0) begin
        for (int i = 159; i > 0; i--) begin ha[i] = ha[i-1]; hb[i] = hb[i-1]; end
        ha[0] = int'($signed(din_a));
        hb[0] = int'($signed(din_b));
      end
      e_cnt++;
    end
    if (coef_we) cq[coef_addr] = int'($signed(coef_wdata)) >>> 4;  // R1 floor
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    chk("res_a", int'(res_a), exp_a);
    chk("res_b", int'(res_b), exp_b);
    chk("res_vld", int'(res_vld), exp_v);
  endtask

  task automatic load_coefs(int mode);
    hold = 1'b1;
    for (int k = 0; k < 128; k++) begin
      coef_we = 1'b1;
      coef_addr = 7'(k);
      coef_wdata = (mode == 0) ? 16'((k * 7919 + 1234) ^ (k << 9)) : 16'h7FFF;
      step();
    end
    coef_we = 1'b0;
  endtask

  task automatic run_seg(string tag, int ts, bit sp, bit dc, int ncyc,
                         bit scramble, bit big);
    cur = tag;
    hold = 1'b1; tap_sel = 2'(ts); split_en = sp; dec_en = dc;
    step(); step();
    hold = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      din_a   = big ? 16'h7FFF : 16'(nxt_rand());
      din_b   = 16'(nxt_rand());
      casc_in = big ? 32'h7FFF_FFF0 : {16'(nxt_rand()), 16'(nxt_rand())};
      if (scramble) begin
        tap_sel = 2'(nxt_rand()); split_en = nxt_rand()[0]; dec_en = nxt_rand()[1];
      end
      step();
    end
  endtask

  initial begin
    rst_n = 1'b0; hold = 1'b1; tap_sel = '0; split_en = 1'b0; dec_en = 1'b0;
    coef_we = 1'b0; coef_addr = '0; coef_wdata = '0;
    din_a = '0; din_b = '0; casc_in = '0;
    repeat (3) @(negedge clk);
    cur = "R10";
    chk("res_a reset", int'(res_a), 0);
    chk("res_b reset", int'(res_b), 0);
    chk("res_vld reset", int'(res_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cur = "R1";
    load_coefs(0);
    run_seg("R1 R2 R6 16 taps", 0, 1'b0, 1'b0, 60, 1'b0, 1'b0);
    run_seg("R3 32 taps", 1, 1'b0, 1'b0, 90, 1'b0, 1'b0);
    run_seg("R3 64 taps", 2, 1'b0, 1'b0, 160, 1'b0, 1'b0);
    run_seg("R3 R9 128 taps", 3, 1'b0, 1'b0, 300, 1'b0, 1'b0);
    run_seg("R4 decimate 32 taps", 1, 1'b0, 1'b1, 90, 1'b0, 1'b0);
    run_seg("R4 decimate 128 taps", 3, 1'b0, 1'b1, 300, 1'b0, 1'b0);
    run_seg("R4 decimate ignored at 16 taps", 0, 1'b0, 1'b1, 40, 1'b0, 1'b0);
    run_seg("R5 split 16 taps", 0, 1'b1, 1'b0, 60, 1'b0, 1'b0);
    run_seg("R5 split 64 taps", 2, 1'b1, 1'b0, 160, 1'b0, 1'b0);
    run_seg("R5 R4 split decimate 128", 3, 1'b1, 1'b1, 300, 1'b0, 1'b0);
    run_seg("R8 mode inputs ignored", 2, 1'b0, 1'b0, 200, 1'b1, 1'b0);
    run_seg("R8 mode inputs ignored split", 1, 1'b1, 1'b1, 120, 1'b1, 1'b0);
    cur = "R1";
    load_coefs(1);
    run_seg("R7 wrap 128 taps", 3, 1'b0, 1'b0, 300, 1'b0, 1'b1);
    run_seg("R7 R6 wrap 16 taps", 0, 1'b0, 1'b0, 40, 1'b0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule